// File: doc/BRIEF.md
# Machine Cycle Timing and Code Fetch Sequencer

This block turns the oscillator clock into the internal timing of a classic 8-bit controller machine cycle. Twelve oscillator periods form one machine cycle: six states S1 to S6, each with a first phase (P1) and a second phase (P2). The block reports the current state and phase. It drives the address latch strobe and the code fetch strobe. It also gives a one-period opcode capture pulse and a program counter advance pulse.

Two code fetches are attempted in every machine cycle, one in each half. The instruction decoder reports three things while the opcode is captured: whether the instruction has one or two bytes, how many machine cycles it runs, and whether it moves external data. From these the sequencer decides which fetched bytes are kept, which are read and thrown away, and which fetches are not issued at all. An internal cycle controller has three named states. CYC_FIRST is the opening cycle of an instruction. CYC_EXTRA is any further cycle of a multi-cycle instruction. CYC_XFER is the data transfer cycle of an external data move. The transitions happen only at S6P2:
- FIRST→FIRST for a one-cycle instruction.
- FIRST→EXTRA when more cycles remain.
- EXTRA→EXTRA while the remaining count is non-zero, and EXTRA→FIRST when it reaches zero.
- FIRST→XFER for an external data move, and XFER→FIRST after it.

Top module: `mcyc_sequencer`

## Requirements
- R1: `state_num` and `phase_p2` step one period at a time through S1P1, S1P2, S2P1 … S6P2 (state 1..6; phase_p2 0 = P1, 1 = P2), then wrap to S1P1.
- R2: `ale` is high in exactly S1P2, S2P1, S4P2 and S5P1 of every machine cycle, including the data transfer cycle.
- R3: In the first cycle of an instruction, `psen` is high in exactly S2P2, S3P1, S3P2, S5P2, S6P1 and S6P2.
- R4: In the second machine cycle of an external data move, `psen` stays low for all twelve periods.
- R5: `op_latch` is high only in S1P2 of an instruction's first cycle. The instruction inputs are sampled in that period.
- R6: `pc_inc` is high in S1P2 of the first cycle. For a two-byte instruction (`instr_len2`=1) it is also high in S4P2 of the first cycle. It is high in no other period, so the S4 byte of a one-byte instruction is discarded.
- R7: An instruction lasts `instr_cycles` machine cycles. A value of 0 counts as 1, and values above MAX_CYC (default 4) count as MAX_CYC. The next `op_latch` comes exactly 12 periods per cycle later.
- R8: When `xdata_move` is 1, the instruction lasts exactly two cycles, whatever `instr_cycles` says.
- R9: With `rst` high at a clock edge, the next period is S1P1 of a first cycle with `ale`, `psen`, `op_latch` and `pc_inc` low.
- R10: In the extra cycles of a multi-cycle instruction that is not an external data move, `psen` follows the R3 pattern, but `pc_inc` stays low (the bytes are discarded).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock, one period per phase |
| rst | input | 1 | Synchronous reset, active high |
| instr_len2 | input | 1 | 1 = two-byte instruction, 0 = one byte; sampled at S1P2 of the first cycle |
| instr_cycles | input | 3 | Machine cycle count of the instruction; sampled with instr_len2 |
| xdata_move | input | 1 | Instruction is an external data move; sampled with instr_len2 |
| state_num | output | 3 | Current state, 1 to 6 |
| phase_p2 | output | 1 | 0 in phase 1, 1 in phase 2 |
| ale | output | 1 | Address latch strobe |
| psen | output | 1 | Code fetch strobe |
| op_latch | output | 1 | Opcode capture pulse |
| pc_inc | output | 1 | Program counter advance pulse |

## Verification
Two situations are hard to reach from the ports. One is the silent cycle of an external data move. The other is the clamping of out-of-range cycle counts. Both only show up one or more whole cycles after the inputs were sampled. The bench sweeps every combination of length, cycle count 0 to 7 and data-move flag, one instruction after another. For each combination it works out the expected strobe of every period from slot and cycle numbers. A reset is also applied partway through a four-cycle instruction, so the controller must leave CYC_EXTRA at once.

// File: rtl/mcyc_pkg.sv
package mcyc_pkg;
    localparam int STATES = 6;
    localparam int SLOTS  = 2 * STATES;
    localparam int HALF   = SLOTS / 2;

    typedef enum logic [1:0] {
        CYC_FIRST,
        CYC_EXTRA,
        CYC_XFER
    } cyc_kind_e;
endpackage

// File: rtl/mcyc_timebase.sv
module mcyc_timebase #(
    parameter  int SLOTS = 12,
    localparam int SW    = $clog2(SLOTS)
) (
    input  logic          clk,
    input  logic          rst,
    output logic [SW-1:0] slot,
    output logic          cyc_end
);
    assign cyc_end = (slot == SW'(SLOTS - 1));

    always_ff @(posedge clk) begin
        if (rst || cyc_end) slot <= '0;
        else                slot <= slot + SW'(1);
    end

    p_slot_step_r1: assert property (@(posedge clk) disable iff (rst)
        !cyc_end |=> (slot == $past(slot) + SW'(1)));
    p_slot_wrap_r1: assert property (@(posedge clk) disable iff (rst)
        cyc_end |=> (slot == '0));
endmodule

// File: rtl/mcyc_instr_ctrl.sv
module mcyc_instr_ctrl
    import mcyc_pkg::*;
#(
    parameter  int MAX_CYC = 4,
    localparam int CW      = $clog2(MAX_CYC + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          op_slot,
    input  logic          cyc_end,
    input  logic          instr_len2,
    input  logic [CW-1:0] instr_cycles,
    input  logic          xdata_move,
    output logic          first_cycle,
    output logic          xfer_cycle,
    output logic          len2_q
);
    cyc_kind_e     state, state_nxt;
    logic          xd_q;
    logic [CW-1:0] ncyc_q, left_q, left_nxt, eff_cyc;

    always_comb begin
        if (instr_cycles == '0)                    eff_cyc = CW'(1);
        else if (instr_cycles > CW'(MAX_CYC))      eff_cyc = CW'(MAX_CYC);
        else                                       eff_cyc = instr_cycles;
    end

    always_comb begin
        state_nxt = state;
        left_nxt  = left_q;
        unique case (state)
            CYC_FIRST: begin
                if (xd_q) begin
                    state_nxt = CYC_XFER;
                end else if (ncyc_q > CW'(1)) begin
                    state_nxt = CYC_EXTRA;
                    left_nxt  = ncyc_q - CW'(2);
                end
            end
            CYC_EXTRA: begin
                if (left_q == '0) state_nxt = CYC_FIRST;
                else              left_nxt  = left_q - CW'(1);
            end
            CYC_XFER:  state_nxt = CYC_FIRST;
            default:   state_nxt = CYC_FIRST;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= CYC_FIRST;
            left_q <= '0;
            len2_q <= 1'b0;
            xd_q   <= 1'b0;
            ncyc_q <= CW'(1);
        end else begin
            if (state == CYC_FIRST && op_slot) begin
                len2_q <= instr_len2;
                xd_q   <= xdata_move;
                ncyc_q <= eff_cyc;
            end
            if (cyc_end) begin
                state  <= state_nxt;
                left_q <= left_nxt;
            end
        end
    end

    assign first_cycle = (state == CYC_FIRST);
    assign xfer_cycle  = (state == CYC_XFER);

    p_xfer_single_r8: assert property (@(posedge clk) disable iff (rst)
        (xfer_cycle && cyc_end) |=> first_cycle);
    p_extra_bound_r7: assert property (@(posedge clk) disable iff (rst)
        (state == CYC_EXTRA) |-> (left_q <= CW'(MAX_CYC - 2)));
    p_state_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !cyc_end |=> (state == $past(state)));
endmodule

// File: rtl/mcyc_strobe_decode.sv
module mcyc_strobe_decode
    import mcyc_pkg::*;
#(
    localparam int SW = $clog2(SLOTS)
) (
    input  logic [SW-1:0] slot,
    input  logic          first_cycle,
    input  logic          xfer_cycle,
    input  logic          len2_q,
    output logic          ale,
    output logic          psen,
    output logic          op_latch,
    output logic          pc_inc
);
    logic ale_win, psen_win;

    always_comb begin
        ale_win  = 1'b0;
        psen_win = 1'b0;
        for (int h = 0; h < 2; h++) begin
            if (slot == SW'(h*HALF + 1) || slot == SW'(h*HALF + 2))
                ale_win = 1'b1;
            if (slot >= SW'(h*HALF + 3) && slot <= SW'(h*HALF + HALF - 1))
                psen_win = 1'b1;
        end
    end

    assign ale      = ale_win;
    assign psen     = psen_win && !xfer_cycle;
    assign op_latch = first_cycle && (slot == SW'(1));
    assign pc_inc   = op_latch || (first_cycle && len2_q && slot == SW'(HALF + 1));

    always_comb begin
        p_ale_psen_excl_r3: assert (!(ale && psen));
        p_op_then_pc_r6:    assert (!op_latch || pc_inc);
    end
endmodule

// File: rtl/mcyc_sequencer.sv
module mcyc_sequencer
    import mcyc_pkg::*;
#(
    parameter  int MAX_CYC = 4,
    localparam int CW      = $clog2(MAX_CYC + 1),
    localparam int SW      = $clog2(SLOTS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          instr_len2,
    input  logic [CW-1:0] instr_cycles,
    input  logic          xdata_move,
    output logic [2:0]    state_num,
    output logic          phase_p2,
    output logic          ale,
    output logic          psen,
    output logic          op_latch,
    output logic          pc_inc
);
    logic [SW-1:0] slot;
    logic          cyc_end, first_cycle, xfer_cycle, len2_q;

    mcyc_timebase #(.SLOTS(SLOTS)) u_tb (
        .clk     (clk),
        .rst     (rst),
        .slot    (slot),
        .cyc_end (cyc_end)
    );

    mcyc_instr_ctrl #(.MAX_CYC(MAX_CYC)) u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .op_slot      (slot == SW'(1)),
        .cyc_end      (cyc_end),
        .instr_len2   (instr_len2),
        .instr_cycles (instr_cycles),
        .xdata_move   (xdata_move),
        .first_cycle  (first_cycle),
        .xfer_cycle   (xfer_cycle),
        .len2_q       (len2_q)
    );

    mcyc_strobe_decode u_dec (
        .slot        (slot),
        .first_cycle (first_cycle),
        .xfer_cycle  (xfer_cycle),
        .len2_q      (len2_q),
        .ale         (ale),
        .psen        (psen),
        .op_latch    (op_latch),
        .pc_inc      (pc_inc)
    );

    assign state_num = 3'(slot[SW-1:1]) + 3'd1;
    assign phase_p2  = slot[0];

    p_reset_home_r9: assert property (@(posedge clk)
        rst |=> (state_num == 3'd1 && !phase_p2 && !ale && !psen && !op_latch && !pc_inc));
    p_psen_after_ale_r3: assert property (@(posedge clk) disable iff (rst)
        ($fell(ale) && !xfer_cycle) |-> psen);
    p_op_at_s1p2_r5: assert property (@(posedge clk) disable iff (rst)
        op_latch |-> (state_num == 3'd1 && phase_p2));
endmodule

// File: tb/mcyc_sequencer_tb.sv
module mcyc_sequencer_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       instr_len2 = 1'b0;
    logic [2:0] instr_cycles = 3'd1;
    logic       xdata_move = 1'b0;
    logic [2:0] state_num;
    logic       phase_p2, ale, psen, op_latch, pc_inc;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    mcyc_sequencer u_dut (
        .clk          (clk),
        .rst          (rst),
        .instr_len2   (instr_len2),
        .instr_cycles (instr_cycles),
        .xdata_move   (xdata_move),
        .state_num    (state_num),
        .phase_p2     (phase_p2),
        .ale          (ale),
        .psen         (psen),
        .op_latch     (op_latch),
        .pc_inc       (pc_inc)
    );

    task automatic chk(input string tag, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s at %0t: got %0d expected %0d", tag, $time, got, exp);
        end
    endtask

    // Checks one slot of cycle k of an instruction; inputs stay as set.
    task automatic chk_slot(input int k, input int t, input bit l2, input int cyc, input bit xd);
        bit exp_ale, exp_psen, exp_op, exp_pc;
        exp_ale  = (t % 6 == 1) || (t % 6 == 2);
        exp_psen = (t % 6 >= 3) && !(xd && k == 1);
        exp_op   = (k == 0) && (t == 1);
        exp_pc   = exp_op || ((k == 0) && l2 && t == 7);
        chk("R1 state", int'(state_num), t / 2 + 1);
        chk("R1 phase", int'(phase_p2), t % 2);
        chk("R2 ale", int'(ale), int'(exp_ale));
        if (xd && k == 1)  chk("R4 psen", int'(psen), int'(exp_psen));
        else if (k > 0)    chk("R10 psen", int'(psen), int'(exp_psen));
        else               chk("R3 psen", int'(psen), int'(exp_psen));
        if (xd)                       chk("R8 op_latch", int'(op_latch), int'(exp_op));
        else if (cyc == 0 || cyc > 4) chk("R7 op_latch", int'(op_latch), int'(exp_op));
        else                          chk("R5 op_latch", int'(op_latch), int'(exp_op));
        if (k > 0) chk("R10 pc_inc", int'(pc_inc), int'(exp_pc));
        else       chk("R6 pc_inc", int'(pc_inc), int'(exp_pc));
    endtask

    // Called at the negedge inside S1P1 of the instruction's first cycle.
    task automatic run_instr(input bit l2, input int cyc, input bit xd);
        int n;
        instr_len2   = l2;
        instr_cycles = 3'(cyc);
        xdata_move   = xd;
        n = xd ? 2 : (cyc == 0 ? 1 : (cyc > 4 ? 4 : cyc));
        for (int k = 0; k < n; k++) begin
            for (int t = 0; t < 12; t++) begin
                chk_slot(k, t, l2, cyc, xd);
                @(negedge clk);
            end
        end
    endtask

    initial begin
        #(20 * 200000);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9: during reset the sequencer sits at S1P1 with strobes low
        chk("R9 state", int'(state_num), 1);
        chk("R9 phase", int'(phase_p2), 0);
        chk("R9 strobes", int'({ale, psen, op_latch, pc_inc}), 0);
        rst = 1'b0;

        for (int xd = 0; xd < 2; xd++)
            for (int c = 0; c < 8; c++)
                for (int l = 0; l < 2; l++)
                    run_instr(l[0], c, xd[0]);

        // R9: reset in the middle of an extra cycle of a four-cycle instruction
        instr_len2 = 1'b0; instr_cycles = 3'd4; xdata_move = 1'b0;
        repeat (12 + 5) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk("R9 state", int'(state_num), 1);
        chk("R9 phase", int'(phase_p2), 0);
        chk("R9 strobes", int'({ale, psen, op_latch, pc_inc}), 0);
        @(negedge clk);
        rst = 1'b0;
        run_instr(1'b1, 1, 1'b0);
        run_instr(1'b0, 1, 1'b0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule